// File: doc/BRIEF.md
# Register-Controlled SPI Master

This block is an SPI bus master that software drives through a 32-bit memory-mapped register port. Software sets the clock mode, the serial clock divisor and the slave-select pattern in a configuration word, turns the controller on through a separate enable word, and then queues bytes by writing the transmit port. Each queued byte is shifted out most significant bit first on MOSI. At the same time, one byte is captured from MISO and placed in a receive queue. Software drains that queue by reading the receive port.

The serial clock comes from the block clock. Its divisor is a power of two chosen by a 3-bit exponent. All four combinations of clock polarity and phase are supported. The four slave-select outputs are copied raw from a 4-bit configuration field. That field can therefore hold an active-low one-hot pattern, or a binary index for an external decoder. Two optional controls change when transfers happen. Forced select keeps the field on the pins at all times. Manual start holds queued bytes back until software writes a trigger bit.

The register port has no back-pressure: a write or read is accepted in the cycle its strobe is high. Reads are combinational. A read of the receive port removes the byte it returns at the next clock edge. The transmit queue has no ready signal. Software must not queue more bytes than the queue holds, because any excess write is discarded.

Top module: `spim_top`

## Requirements
- R1: After reset, the configuration word reads 0x0000_3C09, the enable word reads 0, SCLK is 0 and every slave-select output is high.
- R2: The register offsets are: configuration 0x00, enable 0x14, transmit 0x1C, receive 0x20. Any other offset reads 0. Configuration bits 9:6 and 31:17 always read 0.
- R3: A byte is sent only while both enable bit 0 (offset 0x14) and configuration bit 0 are 1. Otherwise queued bytes wait and SCLK does not toggle.
- R4: With divisor code N in configuration bits 5:3, one SCLK period lasts 2<<N block clock cycles. Code 0 behaves as code 1.
- R5: SCLK rests at the CPOL level (configuration bit 1). With CPHA (bit 2) at 0, the bit is stable for, and sampled on, the first edge of each SCLK period. With CPHA at 1, it is sampled on the second edge. MOSI carries the MSB first, and MISO is sampled on the same edge as MOSI would be sampled by a slave.
- R6: Each byte sent places exactly one received byte in the receive queue. Bytes come out in order, one per read of offset 0x20. A read that falls in the same cycle as a new arrival loses neither byte.
- R7: When bit 14 is 0, the slave-select outputs show field bits 13:10 while a byte is in progress or ready to start, and all ones otherwise. When bit 14 is 1, the outputs show the field at all times. The field is passed unchanged, whether it holds a one-hot pattern or a binary index.
- R8: When bit 15 is 1, queued bytes wait until bit 16 is written as 1. The controller then sends every queued byte back to back. Bit 16 reads 1 from the trigger until the first byte starts, and 0 after that.
- R9: Each queue holds 128 bytes. A transmit write to a full queue is discarded.
- R10: A read of the receive port while the queue is empty returns 0 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the SCLK reference |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive port) |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slaves |
| miso | input | 1 | Serial data from the slaves |
| ss_n | output | 4 | Slave-select outputs |

## Verification
The receive queue can be pushed by the shifter and popped by a software read in the same clock cycle. The bench provokes this on purpose. It counts SCLK edges to find the last edge of the second byte of a burst. It then holds the read strobe high for exactly the cycle in which the shifter pushes that byte. The test is judged by the values returned. The first read must return the first byte. The following reads must return the second and third bytes in order, and then return 0. A lost or duplicated entry shows up as a wrong value or a missing byte.

// File: rtl/spim_pkg.sv
`timescale 1ns/1ps
package spim_pkg;
  localparam int REG_AW = 8;
  localparam int DIV_W  = 3;
  localparam int SS_W   = 4;

  localparam logic [REG_AW-1:0] A_CFG = 8'h00;
  localparam logic [REG_AW-1:0] A_EN  = 8'h14;
  localparam logic [REG_AW-1:0] A_TXD = 8'h1C;
  localparam logic [REG_AW-1:0] A_RXD = 8'h20;

  // configuration bit positions (software visible)
  localparam int B_MASTER = 0;
  localparam int B_CPOL   = 1;
  localparam int B_CPHA   = 2;
  localparam int B_DIV    = 3;
  localparam int B_SS     = 10;
  localparam int B_FORCE  = 14;
  localparam int B_MANUAL = 15;
  localparam int B_TRIG   = 16;

  localparam logic [15:0] CFG_WMASK = 16'hFC3F;
  localparam logic [15:0] CFG_RESET = 16'h3C09;
endpackage

// File: rtl/spim_fifo.sv
`timescale 1ns/1ps
module spim_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == (AW+1)'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = empty ? '0 : mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R9: a push into a full queue leaves the occupancy untouched
  a_r9_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (cnt == $past(cnt)));

  // R10: a pop from an empty queue leaves it empty
  a_r10_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> empty);
endmodule

// File: rtl/spim_shifter.sv
`timescale 1ns/1ps
module spim_shifter #(
  parameter int DIV_W = 3,
  parameter int W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [W-1:0]     tx_byte,
  input  logic             cpol,
  input  logic             cpha,
  input  logic [DIV_W-1:0] div,
  input  logic             miso,
  output logic             busy,
  output logic             done,
  output logic [W-1:0]     rx_byte,
  output logic             sclk,
  output logic             mosi
);
  localparam int CNT_W = (1 << DIV_W) - 1;
  localparam int EDGES = 2 * W;
  localparam int EW    = $clog2(EDGES);

  logic [CNT_W-1:0] cnt, half_q;
  logic [EW-1:0]    eidx;
  logic [W-1:0]     sh, rxs;
  logic             cpha_q;
  logic [DIV_W-1:0] n_eff;
  logic             tick, last, samp, shft;

  assign n_eff = (div == '0) ? DIV_W'(1) : div;
  assign tick  = busy && (cnt == half_q);
  assign last  = (eidx == EW'(EDGES-1));
  assign samp  = cpha_q ? eidx[0] : !eidx[0];
  assign shft  = cpha_q ? (!eidx[0] && (eidx != '0)) : (eidx[0] && !last);
  assign mosi  = sh[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      cnt     <= '0;
      half_q  <= '0;
      eidx    <= '0;
      sh      <= '0;
      rxs     <= '0;
      rx_byte <= '0;
      cpha_q  <= 1'b0;
      sclk    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        sclk <= cpol;
        if (start) begin
          busy   <= 1'b1;
          cnt    <= '0;
          eidx   <= '0;
          sh     <= tx_byte;
          cpha_q <= cpha;
          half_q <= CNT_W'((1 << n_eff) - 1);
        end
      end else if (tick) begin
        cnt  <= '0;
        sclk <= ~sclk;
        if (samp) rxs <= {rxs[W-2:0], miso};
        if (shft) sh  <= {sh[W-2:0], 1'b0};
        if (last) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          rx_byte <= samp ? {rxs[W-2:0], miso} : rxs;
        end else begin
          eidx <= eidx + 1'b1;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R4: inside a byte, SCLK moves only when the half-period count expires
  a_r4_sclk_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> $stable(sclk));

  // R6: the completion pulse comes with the shifter already idle
  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: rtl/spim_top.sv
`timescale 1ns/1ps
module spim_top
  import spim_pkg::*;
#(
  parameter int FIFO_DEPTH = 128,
  parameter int WORD_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [SS_W-1:0]   ss_n
);
  logic [15:0]       cfg;
  logic              en_q, pend, burst;
  logic              wr_cfg, wr_en, tx_push, rx_pop;
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic [WORD_W-1:0] tx_head, rx_head, rx_byte;
  logic              eng_busy, eng_done, can_start;
  logic [SS_W-1:0]   ss_field;
  wire               unused_wdata = ^{bus_wdata[31:17], rx_full};

  assign wr_cfg   = bus_wr && (bus_addr == A_CFG);
  assign wr_en    = bus_wr && (bus_addr == A_EN);
  assign tx_push  = bus_wr && (bus_addr == A_TXD);
  assign rx_pop   = bus_rd && (bus_addr == A_RXD);
  assign ss_field = cfg[B_SS +: SS_W];

  assign can_start = en_q && cfg[B_MASTER] && !tx_empty && !eng_busy &&
                     (!cfg[B_MANUAL] || pend || burst);

  assign ss_n = (cfg[B_FORCE] || eng_busy || can_start) ? ss_field : '1;

  always_comb begin
    case (bus_addr)
      A_CFG:   bus_rdata = {15'b0, pend, cfg};
      A_EN:    bus_rdata = {31'b0, en_q};
      A_RXD:   bus_rdata = 32'(rx_head);
      default: bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg   <= CFG_RESET;
      en_q  <= 1'b0;
      pend  <= 1'b0;
      burst <= 1'b0;
    end else begin
      if (wr_cfg) cfg  <= bus_wdata[15:0] & CFG_WMASK;
      if (wr_en)  en_q <= bus_wdata[0];
      if (wr_cfg && bus_wdata[B_TRIG]) pend <= 1'b1;
      else if (can_start)              pend <= 1'b0;
      if (can_start && cfg[B_MANUAL])  burst <= 1'b1;
      else if (!eng_busy && tx_empty)  burst <= 1'b0;
    end
  end

  spim_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(bus_wdata[WORD_W-1:0]),
    .pop(can_start), .rdata(tx_head), .full(tx_full), .empty(tx_empty));

  spim_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(eng_done), .wdata(rx_byte),
    .pop(rx_pop), .rdata(rx_head), .full(rx_full), .empty(rx_empty));

  spim_shifter #(.DIV_W(DIV_W), .W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(can_start), .tx_byte(tx_head),
    .cpol(cfg[B_CPOL]), .cpha(cfg[B_CPHA]), .div(cfg[B_DIV +: DIV_W]),
    .miso(miso), .busy(eng_busy), .done(eng_done), .rx_byte(rx_byte),
    .sclk(sclk), .mosi(mosi));

  // R3: with the controller off and the shifter idle, nothing starts
  a_r3_gate: assert property (@(posedge clk) disable iff (!rst_n)
    ((!en_q || !cfg[B_MASTER]) && !eng_busy) |=> !eng_busy);

  // R7: the field is on the select pins throughout a byte
  a_r7_ss_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    eng_busy |-> (ss_n == ss_field));

  // R8: manual start holds off the shifter until a trigger arrives
  a_r8_manual_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[B_MANUAL] && !pend && !burst && !eng_busy) |=> !eng_busy);

  // R9: a transmit write is never taken while the queue is full
  a_r9_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push && tx_full && !can_start) |=> tx_full);
endmodule

// File: tb/tb_spim_top.sv
`timescale 1ns/1ps
module tb_spim_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sclk, mosi, miso;
  logic [3:0]  ss_n;
  logic        inv = 1'b0;

  int total = 0, bad = 0;
  int edges = 0;
  logic       mon_en = 1'b0, b_cpol = 1'b0, b_cpha = 1'b0;
  logic [7:0] cap = '0;
  int         cur_n = 1;

  always #10 clk = ~clk;
  assign miso = mosi ^ inv;

  spim_top dut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n));

  always @(sclk) if (mon_en) edges++;
  always @(posedge sclk) if (mon_en && !(b_cpol ^ b_cpha)) cap <= {cap[6:0], mosi};
  always @(negedge sclk) if (mon_en &&  (b_cpol ^ b_cpha)) cap <= {cap[6:0], mosi};

  task automatic check(input logic ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a; #2 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  function automatic logic [31:0] mk(input logic master, input logic cpol, input logic cpha,
      input int n, input logic [3:0] ss, input logic force_ss, input logic manual,
      input logic trig);
    return {15'b0, trig, manual, force_ss, ss, 4'b0, 3'(n), cpha, cpol, master};
  endfunction

  task automatic wait_bytes(input int nb);
    int ne = (cur_n == 0) ? 1 : cur_n;
    repeat (nb * (16 << ne) + 12) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic mon_restart(input logic cpol, input logic cpha);
    mon_en = 1'b0; b_cpol = cpol; b_cpha = cpha;
    repeat (3) @(posedge clk);
    edges = 0; cap = '0; mon_en = 1'b1;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(8'h00, v); check(v == 32'h0000_3C09, "R1 cfg reset", v, 32'h3C09);
    rd(8'h14, v); check(v == 0, "R1 enable reset", v, 0);
    check(sclk == 1'b0 && ss_n == 4'hF, "R1 pins", {sclk, ss_n}, 5'h0F);
    rd(8'h04, v); check(v == 0, "R2 unmapped", v, 0);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, v); check(v == 32'h0001_FC3F, "R2 cfg mask", v, 32'h0001_FC3F);
  endtask

  task automatic t_enable();
    logic [31:0] v;
    cur_n = 1; inv = 1'b0;
    wr(8'h14, 1);
    wr(8'h00, mk(0, 0, 0, 1, 4'hE, 0, 0, 0));
    mon_restart(0, 0);
    wr(8'h1C, 8'hA5);
    repeat (100) @(posedge clk); @(negedge clk);
    check(edges == 0 && ss_n == 4'hF, "R3 master bit off", edges, 0);
    wr(8'h00, mk(1, 0, 0, 1, 4'hE, 0, 0, 0));
    wait_bytes(1);
    check(edges == 16, "R3 sent once on", edges, 16);
    rd(8'h20, v); check(v == 32'hA5, "R6 loopback byte", v, 32'hA5);
    wr(8'h14, 0);
    mon_restart(0, 0);
    wr(8'h1C, 8'h3D);
    repeat (100) @(posedge clk); @(negedge clk);
    check(edges == 0, "R3 enable word off", edges, 0);
    wr(8'h14, 1);
    wait_bytes(1);
    rd(8'h20, v); check(v == 32'h3D, "R3 resumes", v, 32'h3D);
  endtask

  task automatic t_modes();
    logic [31:0] v;
    cur_n = 1; inv = 1'b1;
    for (int m = 0; m < 4; m++) begin
      logic [7:0] b = 8'hC5 ^ 8'(m * 8'h13);
      wr(8'h00, mk(1, m[1], m[0], 1, 4'hE, 0, 0, 0));
      mon_restart(m[1], m[0]);
      wr(8'h1C, {24'b0, b});
      wait_bytes(1);
      check(cap == b, "R5 mosi capture", cap, b);
      check(sclk == m[1], "R5 idle level", sclk, m[1]);
      rd(8'h20, v); check(v == {24'b0, ~b}, "R5 miso sample", v, ~b);
    end
    inv = 1'b0;
  endtask

  task automatic t_period(input int n, input time exp);
    logic [31:0] v;
    time t0, t1;
    cur_n = n;
    wr(8'h00, mk(1, 0, 0, n, 4'hE, 0, 0, 0));
    wr(8'h1C, 8'h77);
    @(posedge sclk); t0 = $time;
    @(posedge sclk); t1 = $time;
    check((t1 - t0) == exp, "R4 sclk period", t1 - t0, exp);
    wait_bytes(1);
    rd(8'h20, v);
  endtask

  task automatic t_ss();
    logic [31:0] v;
    cur_n = 1;
    wr(8'h00, mk(1, 0, 0, 1, 4'b1011, 1, 0, 0));
    @(negedge clk); check(ss_n == 4'b1011, "R7 forced idle", ss_n, 4'b1011);
    wr(8'h00, mk(1, 0, 0, 1, 4'b0010, 0, 0, 0));
    @(negedge clk); check(ss_n == 4'hF, "R7 auto idle", ss_n, 4'hF);
    wr(8'h1C, 8'h81);
    repeat (10) @(negedge clk);
    check(ss_n == 4'b0010, "R7 binary index in xfer", ss_n, 4'b0010);
    wait_bytes(1);
    check(ss_n == 4'hF, "R7 release", ss_n, 4'hF);
    rd(8'h20, v);
  endtask

  task automatic t_manual();
    logic [31:0] v;
    cur_n = 1;
    wr(8'h00, mk(1, 0, 0, 1, 4'hE, 0, 1, 0));
    mon_restart(0, 0);
    wr(8'h1C, 8'h5A); wr(8'h1C, 8'h6B);
    repeat (100) @(posedge clk); @(negedge clk);
    check(edges == 0 && ss_n == 4'hF, "R8 held", edges, 0);
    wr(8'h14, 0);
    wr(8'h00, mk(1, 0, 0, 1, 4'hE, 0, 1, 1));
    rd(8'h00, v); check(v[16] == 1'b1, "R8 trigger pending", v[16], 1);
    wr(8'h14, 1);
    wait_bytes(2);
    rd(8'h00, v); check(v[16] == 1'b0, "R8 trigger cleared", v[16], 0);
    check(edges == 32, "R8 burst both", edges, 32);
    rd(8'h20, v); check(v == 32'h5A, "R8 first", v, 32'h5A);
    rd(8'h20, v); check(v == 32'h6B, "R8 second", v, 32'h6B);
  endtask

  task automatic t_full();
    logic [31:0] v;
    int mism = 0;
    cur_n = 1;
    wr(8'h14, 0);
    wr(8'h00, mk(1, 0, 0, 1, 4'hE, 0, 0, 0));
    for (int i = 0; i < 130; i++) wr(8'h1C, 32'(i + 1));
    wr(8'h14, 1);
    wait_bytes(130);
    for (int i = 0; i < 128; i++) begin
      rd(8'h20, v);
      if (v != 32'(i + 1)) mism++;
    end
    check(mism == 0, "R9 128 bytes in order", mism, 0);
    rd(8'h20, v); check(v == 0, "R9 extra writes dropped", v, 0);
    rd(8'h20, v); check(v == 0, "R10 empty read", v, 0);
  endtask

  task automatic t_concurrent();
    logic [31:0] v, first;
    cur_n = 1;
    wr(8'h00, mk(1, 0, 0, 1, 4'hE, 0, 0, 0));
    mon_restart(0, 0);
    wr(8'h1C, 8'h11); wr(8'h1C, 8'h22); wr(8'h1C, 8'h33);
    wait (edges == 32);
    @(negedge clk); bus_rd = 1'b1; bus_addr = 8'h20; #2 first = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
    check(first == 32'h11, "R6 read during push", first, 32'h11);
    wait_bytes(1);
    rd(8'h20, v); check(v == 32'h22, "R6 pushed byte kept", v, 32'h22);
    rd(8'h20, v); check(v == 32'h33, "R6 third byte", v, 32'h33);
    rd(8'h20, v); check(v == 0, "R10 drained", v, 0);
  endtask

  initial begin
    #4_000_000;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_enable();
    t_modes();
    t_period(2, 160);
    t_period(0, 80);
    t_ss();
    t_manual();
    t_full();
    t_concurrent();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule